// File: doc/BRIEF.md
# Four-Channel Sampling Converter Serial Host

This block is the host side of a serial link to a four-channel, 12-bit sampling converter that takes its conversion clock from the link's own serial clock. A one-cycle request starts one transfer. The controller pulls its active-low select line low. It then runs exactly sixteen serial clock periods and drops the select line again. The select line both starts the conversion and frames the transfer. While the transfer runs, the controller shifts out a control word built from the channel, sequencer, range and coding inputs. At the same time it collects the sixteen returned bits.

Each returned frame begins with two bits that must be zero. Next come two bits that tag the channel and then twelve result bits, most significant first. The controller checks the two leading bits. It takes the channel number from the frame itself, not from the request, and strobes the result out. When the coding input chosen for the frame selects twos complement, it also gives an offset-binary copy of the result. A frame with a bad leading bit raises an error pulse and gives no result strobe.

The serial clock is made by dividing the system clock and idles high. The select line then stays high for a fixed guard time. Requests that arrive while a transfer or its guard time is running are dropped, and the busy output shows this.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, `ser_cs_n` and `ser_clk` are high and `busy`, `res_valid` and `frame_err` are low.
- R2: A request accepted while idle drives `ser_cs_n` low for exactly 16 falling edges of `ser_clk`. `ser_clk` is always high while `ser_cs_n` is high.
- R3: The control word is sent most significant bit first on `ser_mosi`: bit 15 = 1 (write), bits 14:13 = `cfg_seq`, bits 12:11 = `cfg_addr`, bit 10 = `cfg_range`, bit 9 = `cfg_coding`, bits 8:0 = 0. The inputs are captured when the request is accepted. `ser_mosi` changes only while `ser_clk` is high, so every bit is stable across its falling edge.
- R4: `ser_miso` is sampled on the rising edge of `ser_clk` that follows each falling edge. The first sample is frame bit 15 (most significant).
- R5: After a frame with both leading bits zero, `res_valid` pulses high for one system clock. At that time `res_chan` equals frame bits 13:12, `res_raw` equals frame bits 11:0, and `ser_cs_n` is already high.
- R6: With the coding captured at the request equal to 1 (twos complement), `res_offbin` is `res_raw` with bit 11 inverted. With coding 0 (straight binary), `res_offbin` equals `res_raw`.
- R7: If frame bit 15 or bit 14 is 1, `frame_err` pulses for one clock and `res_valid` stays low for that frame. The two never go high together.
- R8: `busy` is high from the clock after a request is accepted until the guard time ends. Between two frames `ser_cs_n` stays high for at least 2·GAP_PERIODS·DIV_HALF system clocks.
- R9: A request made while `busy` is high is dropped: it starts no extra frame, either during the transfer or in the clock of the result strobe.
- R10: Each half period of `ser_clk` lasts DIV_HALF system clocks. `ser_clk` is low for 16·DIV_HALF clocks per frame and `ser_cs_n` is low for 32·DIV_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start one transfer (taken only when idle) |
| cfg_addr | input | 2 | Channel address for the control word |
| cfg_seq | input | 2 | Sequencer field for the control word |
| cfg_range | input | 1 | Range select for the control word |
| cfg_coding | input | 1 | Coding select: 1 = twos complement, 0 = straight binary |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_cs_n | output | 1 | Active-low select / conversion start |
| ser_mosi | output | 1 | Control bits to the converter |
| ser_miso | input | 1 | Result bits from the converter |
| busy | output | 1 | Transfer or guard time in progress |
| res_valid | output | 1 | One-clock result strobe |
| res_chan | output | 2 | Channel tag taken from the frame |
| res_raw | output | 12 | Result as received |
| res_offbin | output | 12 | Result normalised to offset binary |
| frame_err | output | 1 | One-clock pulse when a leading bit is nonzero |

## Verification
The result strobe at the end of one frame and a new request can fall in the same system clock. The guard time has already begun by then, so that request must be dropped. The bench provokes this by holding `req` high across two back-to-back transfers, so the request is present in the strobe cycle. It then judges the case in three ways. `ser_cs_n` must already be high during the strobe. Only one new frame may start. That frame may begin only after the full guard time, which the bench measures in system clocks.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int CHAN_BITS  = 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic       wr;
        logic [1:0] seq;
        logic [1:0] addr;
        logic       rng;
        logic       coding;
    } ctrl_cfg_t;

endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST) && !restart;

    always_comb begin
        cnt_d = cnt_q;
        if (restart || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_ctrl_word.sv
module adc_ctrl_word
    import adc_host_pkg::*;
(
    input  ctrl_cfg_t               cfg,
    output logic [FRAME_BITS-1:0]   word
);
    localparam int PAD = FRAME_BITS - $bits(ctrl_cfg_t);

    always_comb begin
        word = {cfg.wr, cfg.seq, cfg.addr, cfg.rng, cfg.coding, {PAD{1'b0}}};
    end

endmodule

// File: rtl/adc_result_decode.sv
module adc_result_decode
    import adc_host_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  coding,
    output logic                  valid,
    output logic                  err,
    output logic [CHAN_BITS-1:0]  chan,
    output logic [DATA_BITS-1:0]  raw,
    output logic [DATA_BITS-1:0]  offbin
);
    localparam int LEAD_HI = FRAME_BITS - 1;
    localparam int LEAD_LO = FRAME_BITS - 2;
    localparam int TAG_HI  = LEAD_LO - 1;
    localparam int TAG_LO  = DATA_BITS;

    typedef struct packed {
        logic                 valid;
        logic                 err;
        logic [CHAN_BITS-1:0] chan;
        logic [DATA_BITS-1:0] raw;
        logic [DATA_BITS-1:0] offbin;
    } dec_t;

    dec_t r_d, r_q;
    logic lead_bad;
    logic [DATA_BITS-1:0] body;

    always_comb begin
        lead_bad = |frame[LEAD_HI:LEAD_LO];
        body     = frame[DATA_BITS-1:0];
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        if (done) begin
            if (lead_bad) begin
                r_d.err = 1'b1;
            end else begin
                r_d.valid  = 1'b1;
                r_d.chan   = frame[TAG_HI:TAG_LO];
                r_d.raw    = body;
                r_d.offbin = coding ? {~body[DATA_BITS-1], body[DATA_BITS-2:0]} : body;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid  = r_q.valid;
    assign err    = r_q.err;
    assign chan   = r_q.chan;
    assign raw    = r_q.raw;
    assign offbin = r_q.offbin;

    // R7
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && err));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int DIV_HALF    = 2,
    parameter int GAP_PERIODS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [1:0]           cfg_addr,
    input  logic [1:0]           cfg_seq,
    input  logic                 cfg_range,
    input  logic                 cfg_coding,
    output logic                 ser_clk,
    output logic                 ser_cs_n,
    output logic                 ser_mosi,
    input  logic                 ser_miso,
    output logic                 busy,
    output logic                 res_valid,
    output logic [1:0]           res_chan,
    output logic [11:0]          res_raw,
    output logic [11:0]          res_offbin,
    output logic                 frame_err
);
    localparam int GAP_HALVES = 2 * GAP_PERIODS;
    localparam int GW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [GW-1:0]    GAP_LAST = GW'(GAP_HALVES - 1);
    localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        phase_e                phase;
        logic                  sclk;
        logic                  cs_n;
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
        logic [IDX_W-1:0]      bit_idx;
        logic [GW-1:0]         gap_idx;
        logic                  coding;
        logic                  done;
    } host_t;

    host_t s_d, s_q;
    ctrl_cfg_t cfg_now;
    logic [FRAME_BITS-1:0] word_now;
    logic half_tick;
    logic timer_restart;

    assign cfg_now = '{wr: 1'b1, seq: cfg_seq, addr: cfg_addr,
                       rng: cfg_range, coding: cfg_coding};

    adc_ctrl_word u_word (
        .cfg  (cfg_now),
        .word (word_now)
    );

    assign timer_restart = (s_q.phase == PH_IDLE);

    adc_half_timer #(.HALF(DIV_HALF)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .tick    (half_tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req) begin
                    s_d.phase   = PH_HIGH;
                    s_d.cs_n    = 1'b0;
                    s_d.sclk    = 1'b1;
                    s_d.tx      = word_now;
                    s_d.coding  = cfg_coding;
                    s_d.bit_idx = '0;
                end
            end
            PH_HIGH: begin
                if (half_tick) begin
                    s_d.phase = PH_LOW;
                    s_d.sclk  = 1'b0;
                end
            end
            PH_LOW: begin
                if (half_tick) begin
                    s_d.sclk = 1'b1;
                    s_d.rx   = {s_q.rx[FRAME_BITS-2:0], ser_miso};
                    if (s_q.bit_idx == BIT_LAST) begin
                        s_d.phase   = PH_GAP;
                        s_d.cs_n    = 1'b1;
                        s_d.done    = 1'b1;
                        s_d.gap_idx = '0;
                    end else begin
                        s_d.phase   = PH_HIGH;
                        s_d.bit_idx = s_q.bit_idx + 1'b1;
                        s_d.tx      = {s_q.tx[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
            PH_GAP: begin
                if (half_tick) begin
                    if (s_q.gap_idx == GAP_LAST) begin
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.gap_idx = s_q.gap_idx + 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_IDLE;
            s_q.sclk    <= 1'b1;
            s_q.cs_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    adc_result_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (s_q.done),
        .frame  (s_q.rx),
        .coding (s_q.coding),
        .valid  (res_valid),
        .err    (frame_err),
        .chan   (res_chan),
        .raw    (res_raw),
        .offbin (res_offbin)
    );

    assign ser_clk  = s_q.sclk;
    assign ser_cs_n = s_q.cs_n;
    assign ser_mosi = s_q.tx[FRAME_BITS-1];
    assign busy     = (s_q.phase != PH_IDLE);

    // R2
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> ser_clk);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && !$past(ser_clk)) |-> $stable(ser_mosi));

    // R5
    strobe_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ser_cs_n);

    // R8
    gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_cs_n) |-> busy);

endmodule

// File: tb/sim_adc_serial_host.sv
`timescale 1ns/1ps
module sim_adc_serial_host;
    localparam int H   = 2;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [1:0] cfg_addr = '0, cfg_seq = '0;
    logic cfg_range = 1'b0, cfg_coding = 1'b0;
    logic ser_clk, ser_cs_n, ser_mosi;
    logic ser_miso = 1'b0;
    logic busy, res_valid, frame_err;
    logic [1:0] res_chan;
    logic [11:0] res_raw, res_offbin;

    int checks = 0;
    int fails  = 0;

    logic [15:0] frame_bits = '0;
    logic [15:0] ctl_seen = '0;
    int idx = 0, falls = 0, lowcnt = 0, cslow = 0, starts = 0;

    always #5 clk = ~clk;

    adc_serial_host #(.DIV_HALF(H), .GAP_PERIODS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_addr(cfg_addr), .cfg_seq(cfg_seq),
        .cfg_range(cfg_range), .cfg_coding(cfg_coding), .ser_clk(ser_clk),
        .ser_cs_n(ser_cs_n), .ser_mosi(ser_mosi), .ser_miso(ser_miso), .busy(busy),
        .res_valid(res_valid), .res_chan(res_chan), .res_raw(res_raw),
        .res_offbin(res_offbin), .frame_err(frame_err)
    );

    // converter model: samples control bit and launches result bit on falling edge
    always @(negedge ser_cs_n) begin
        idx = 0;
        starts = starts + 1;
    end
    always @(negedge ser_clk) begin
        if (!ser_cs_n) begin
            ctl_seen = {ctl_seen[14:0], ser_mosi};
            ser_miso = (idx < 16) ? frame_bits[15 - idx] : 1'b0;
            idx   = idx + 1;
            falls = falls + 1;
        end
    end
    always @(negedge clk) begin
        if (!ser_cs_n) cslow = cslow + 1;
        if (!ser_cs_n && !ser_clk) lowcnt = lowcnt + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_frame(input logic [1:0] a, input logic [1:0] sq, input logic rg,
                            input logic cd, input logic [1:0] lead, input logic [1:0] tag,
                            input logic [11:0] dat);
        logic got_v, got_e;
        logic [1:0] g_ch;
        logic [11:0] g_raw, g_ob, exp_ob;
        logic [15:0] exp_ctl;
        frame_bits = {lead, tag, dat};
        falls = 0; lowcnt = 0; cslow = 0; starts = 0;
        got_v = 0; got_e = 0; g_ch = 0; g_raw = 0; g_ob = 0;
        @(negedge clk);
        cfg_addr = a; cfg_seq = sq; cfg_range = rg; cfg_coding = cd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        repeat (3) @(negedge clk);
        req = 1'b1; cfg_coding = ~cd;          // R9: dropped while busy
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (res_valid || frame_err) begin
                got_v = res_valid; got_e = frame_err;
                g_ch = res_chan; g_raw = res_raw; g_ob = res_offbin;
                break;
            end
        end
        @(negedge clk);
        chk(!res_valid && !frame_err, "R5 strobe one clock", {res_valid, frame_err}, 0);
        if (lead != 2'b00) begin
            chk(got_e && !got_v, "R7 leading bit error", {got_v, got_e}, 1);
        end else begin
            exp_ob = cd ? {~dat[11], dat[10:0]} : dat;
            chk(got_v && !got_e, "R5 valid strobe", {got_v, got_e}, 2);
            chk(g_ch == tag, "R5 channel from frame", g_ch, tag);
            chk(g_raw == dat, "R4 raw result", g_raw, dat);
            chk(g_ob == exp_ob, "R6 offset binary", g_ob, exp_ob);
        end
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        exp_ctl = {1'b1, sq, a, rg, cd, 9'b0};
        chk(falls == 16, "R2 falling edges", falls, 16);
        chk(ctl_seen == exp_ctl, "R3 control word", ctl_seen, exp_ctl);
        chk(lowcnt == 16 * H, "R10 clock low time", lowcnt, 16 * H);
        chk(cslow == 32 * H, "R10 select low time", cslow, 32 * H);
        chk(starts == 1, "R9 single frame", starts, 1);
    endtask

    logic [11:0] pats [6];

    initial begin
        #(200000 * 10);
        fails = fails + 1;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        int gapcnt;
        logic cs_at_strobe;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ser_cs_n && ser_clk, "R1 idle lines", {ser_cs_n, ser_clk}, 3);
        chk(!busy && !res_valid && !frame_err, "R1 idle flags",
            {busy, res_valid, frame_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_cs_n && ser_clk && !busy, "R1 after release", {ser_cs_n, ser_clk, busy}, 6);

        for (int ch = 0; ch < 4; ch++) begin
            for (int cd = 0; cd < 2; cd++) begin
                pats[0] = 12'h000; pats[1] = 12'h001; pats[2] = 12'h7FF;
                pats[3] = 12'h800; pats[4] = 12'hFFF;
                pats[5] = 12'((ch * 12'h3A5 + cd * 12'h111 + 12'h5C) & 12'hFFF);
                for (int p = 0; p < 6; p++) begin
                    do_frame(2'(ch), 2'(ch ^ (cd * 3)), pats[p][0], 1'(cd), 2'b00,
                             2'(3 - ch), pats[p]);
                end
            end
        end
        // R7 error frames
        do_frame(2'd1, 2'd0, 1'b0, 1'b0, 2'b01, 2'd1, 12'hABC);
        do_frame(2'd2, 2'd1, 1'b1, 1'b1, 2'b10, 2'd2, 12'h123);
        do_frame(2'd3, 2'd3, 1'b0, 1'b1, 2'b11, 2'd3, 12'hFFF);
        do_frame(2'd0, 2'd2, 1'b1, 1'b1, 2'b00, 2'd0, 12'h800);

        // R8 / R9: request held through the result strobe
        frame_bits = {2'b00, 2'd2, 12'h456};
        starts = 0; cs_at_strobe = 0;
        @(negedge clk);
        cfg_coding = 1'b0; req = 1'b1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (res_valid) begin
                cs_at_strobe = ser_cs_n;
                break;
            end
        end
        chk(cs_at_strobe == 1'b1, "R9 select high at strobe", cs_at_strobe, 1);
        gapcnt = 1;
        for (int k = 0; k < 200 && ser_cs_n; k++) begin
            @(negedge clk);
            if (ser_cs_n) gapcnt = gapcnt + 1;
        end
        req = 1'b0;
        chk(gapcnt >= 4 * H, "R8 guard time", gapcnt, 4 * H);
        chk(starts == 2, "R9 strobe-cycle request dropped", starts, 2);
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        chk(!busy && ser_cs_n, "R8 busy clears", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule